// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the two-wire bus slave that sits in front of a small byte-addressed memory array. It watches the clock and data lines through synchronizers and finds start and stop conditions. It shifts bytes in on rising clock edges and decides whether to acknowledge each one. It shifts read data out on falling clock edges. A single address counter serves every read and keeps its value from one transaction to the next. A master can therefore read the current location with nothing more than a device byte. It can also stream consecutive bytes, or first set the counter with an address-only write.

A byte write is held until the master sends a stop. The byte is then committed to the memory port in one clock, and the block enters a timed busy period that stands in for the slow programming of a nonvolatile cell. While busy, the slave does not acknowledge its device byte. The master polls with start conditions until an acknowledge returns.

The memory port is a plain synchronous port with no valid/ready handshake. The bus leaves many system clocks between requests, so nothing ever waits. The address output is always the counter value, and read data must be valid one clock after the address changes. A write is a one-clock strobe that cannot be refused.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the address counter (seen on `mem_addr_o`) is 0, `sda_pull_o` is 0 and `mem_we_o` is 0.
- R2: A device byte is acknowledged only when bits 7:4 are 1010, bit 3 is 0 and bits 2:1 equal `dev_sel_i`. Bit 0 selects read (1) or write (0). On a mismatch the slave acknowledges nothing and drives nothing until the next start.
- R3: After an acknowledged read device byte, the slave sends the byte at the counter, most significant bit first, and the counter advances by one.
- R4: A master acknowledge in the ninth clock of a read byte makes the slave send the next byte. A master no-acknowledge releases the line, and the slave stays silent until a start or stop.
- R5: In a write, the byte after the device byte loads the counter, and the next byte is acknowledged and held. At the stop, `mem_we_o` pulses for exactly one clock with that address and data, and the counter then holds that address plus one. A write stopped right after the address byte sets the counter and writes nothing.
- R6: For WR_CYCLES clocks after a committed write, no device byte is acknowledged, whatever its R/W bit. After that period the slave acknowledges again.
- R7: The counter wraps from the last array address to 0.
- R8: A start in any state returns the slave to device-byte reception. It discards a held write and keeps the counter.
- R9: Within one write, data bytes after the first are not acknowledged, and only the first is committed.
- R10: The slave changes `sda_pull_o` only while the synchronized clock is low.
- R11: A stop during the ninth clock of a read byte ends the transfer: the line is released, and the counter keeps the value it took when that byte was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_sel_i | input | 2 | Device select bits compared with bits 2:1 of the device byte |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |
| mem_addr_o | output | AW | Memory address, equal to the address counter |
| mem_rdata_i | input | 8 | Read data, valid one clock after the address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | One-clock write strobe |

## Verification
A wrong address counter shows on `mem_addr_o` at once. It shows on the data line within one byte time, because every read returns the byte at the counter. A stuck state machine appears within nine bus clocks, either as a missing or extra acknowledge or as a byte the bench did not expect. A busy timer of the wrong length appears at the first polling attempt. The bench polls both inside the window and after it, so an early or absent acknowledge is caught on that device byte.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DEVADR, S_DEVACK, S_WORD, S_WORDACK, S_DATA, S_DATAACK,
    S_SKIP, S_SKIPACK, S_SEND, S_MACK, S_HOLD
  } smem_state_t;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_pin};
      sda_ff <= {sda_ff[STAGES-2:0], sda_pin};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/smem_addr_ctr.sv
module smem_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] q
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= (q == LAST) ? '0 : q + 1'b1;
  end

  AST_CTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && q == LAST) |=> (q == '0)); // R7
endmodule

// File: rtl/smem_wcycle.sv
module smem_wcycle #(
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (start)        remain <= CW'(WR_CYCLES);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  AST_BUSY_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R6
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import smem_pkg::*;
#(
  parameter int AW          = 8,
  parameter int WR_CYCLES   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    dev_sel_i,
  output logic          sda_pull_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic busy;
  smem_state_t st;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, wr_data;
  logic pull, rw_rd, m_acked, wr_pend, commit;
  logic byte_done, dev_match, rx_phase, quiet;
  logic ctr_load, ctr_inc, send_load;
  logic [AW-1:0] ctr_q;

  smem_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl_i), .sda_pin(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det));

  smem_addr_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(AW'(rx_sh)),
    .inc(ctr_inc), .q(ctr_q));

  smem_wcycle #(.WR_CYCLES(WR_CYCLES)) u_wcyc (
    .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy));

  always_comb begin
    byte_done = (bit_cnt == 4'd8);
    quiet     = !start_det && !stop_det;
    dev_match = (rx_sh[7:4] == DEV_CODE) && !rx_sh[3] && (rx_sh[2:1] == dev_sel_i);
    rx_phase  = (st == S_DEVADR) || (st == S_WORD) || (st == S_DATA) || (st == S_SKIP);
    ctr_load  = quiet && scl_fall && (st == S_WORD) && byte_done;
    send_load = quiet && scl_fall &&
                (((st == S_DEVACK) && rw_rd) || ((st == S_MACK) && m_acked));
    ctr_inc   = send_load || commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      wr_data <= '0;
      pull    <= 1'b0;
      rw_rd   <= 1'b0;
      m_acked <= 1'b0;
      wr_pend <= 1'b0;
      commit  <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start_det) begin
        st      <= S_DEVADR;
        bit_cnt <= '0;
        pull    <= 1'b0;
        wr_pend <= 1'b0;
      end else if (stop_det) begin
        st      <= S_IDLE;
        pull    <= 1'b0;
        commit  <= wr_pend;
        wr_pend <= 1'b0;
      end else begin
        if (scl_rise && rx_phase && !byte_done) begin
          rx_sh   <= {rx_sh[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 4'd1;
        end
        if (scl_rise && st == S_MACK) m_acked <= !sda_lvl;
        if (send_load) begin
          tx_sh   <= {mem_rdata_i[6:0], 1'b0};
          pull    <= !mem_rdata_i[7];
          bit_cnt <= 4'd1;
          st      <= S_SEND;
        end else if (scl_fall) begin
          case (st)
            S_DEVADR: if (byte_done) begin
              if (dev_match && !busy) begin
                pull  <= 1'b1;
                rw_rd <= rx_sh[0];
                st    <= S_DEVACK;
              end else begin
                st <= S_IDLE;
              end
            end
            S_DEVACK: begin
              pull    <= 1'b0;
              bit_cnt <= '0;
              st      <= S_WORD;
            end
            S_WORD: if (byte_done) begin
              pull <= 1'b1;
              st   <= S_WORDACK;
            end
            S_WORDACK: begin
              pull    <= 1'b0;
              bit_cnt <= '0;
              st      <= S_DATA;
            end
            S_DATA: if (byte_done) begin
              pull    <= 1'b1;
              wr_data <= rx_sh;
              st      <= S_DATAACK;
            end
            S_DATAACK: begin
              pull    <= 1'b0;
              wr_pend <= 1'b1;
              bit_cnt <= '0;
              st      <= S_SKIP;
            end
            S_SKIP: if (byte_done) st <= S_SKIPACK;
            S_SKIPACK: begin
              bit_cnt <= '0;
              st      <= S_SKIP;
            end
            S_SEND: begin
              if (byte_done) begin
                pull <= 1'b0;
                st   <= S_MACK;
              end else begin
                pull    <= !tx_sh[7];
                tx_sh   <= {tx_sh[6:0], 1'b0};
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
            S_MACK: begin
              pull <= 1'b0;
              st   <= S_HOLD;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_pull_o  = pull;
  assign mem_addr_o  = ctr_q;
  assign mem_wdata_o = wr_data;
  assign mem_we_o    = commit;

  AST_SDA_MOVES_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull) |-> !scl_lvl); // R10
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEVADR && scl_fall && byte_done && busy && quiet) |=> !pull); // R6
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o); // R5
  AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_HOLD || st == S_SKIP) |-> !pull); // R4
  AST_NO_LOAD_AND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !ctr_load); // R5
endmodule

// File: tb/serial_mem_slave_test.sv
module serial_mem_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int WRC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] dev_sel = 2'b01;
  logic sda_pull, mem_we;
  logic [7:0] mem_addr, mem_rdata, mem_wdata;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  logic [7:0] last_wa, last_wd;
  int bad_edges = 0;
  logic prev_pull = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  serial_mem_slave #(.AW(8), .WR_CYCLES(WRC), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .dev_sel_i(dev_sel), .sda_pull_o(sda_pull), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we));

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt  = we_cnt + 1;
      last_wa = mem_addr;
      last_wd = mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
    if (sda_pull !== prev_pull && scl) bad_edges = bad_edges + 1;
    prev_pull = sda_pull;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (got_q.size() != 0 && exp_q.size() != 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(H/2); m_sda = 1'b1; tick(H/2);
    scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(H/2); m_sda = 1'b0; tick(H/2);
    scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(H/2); m_sda = b[i]; tick(H/2);
      scl = 1'b1; tick(H);
      scl = 1'b0;
    end
    tick(H/2); m_sda = 1'b1; tick(H/2);
    scl = 1'b1; tick(H/2);
    ack = ~sda_bus;
    tick(H/2);
    scl = 1'b0;
  endtask

  task automatic clock_in8(output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl = 1'b1; tick(H/2);
      b[i] = sda_bus;
      tick(H/2);
      scl = 1'b0;
    end
  endtask

  task automatic read_byte(input bit mack, input logic [7:0] exp, input string tag);
    logic [7:0] b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    clock_in8(b);
    got_q.push_back(b);
    tick(H/2); m_sda = ~mack; tick(H/2);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(H/2);
    m_sda = 1'b1;
  endtask

  localparam logic [7:0] DW = 8'hA2;
  localparam logic [7:0] DR = 8'hA3;

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    tick(5);
    chk(sda_pull == 1'b0 && mem_we == 1'b0, "R1 outputs idle after reset", sda_pull, 0);
    chk(mem_addr == 8'h00, "R1 counter zero after reset", mem_addr, 0);
    rst_n = 1'b1;
    tick(5);

    // R2 R3: current address read at power-up
    bus_start(); send_byte(DR, ack);
    chk(ack, "R2 matching read device byte acked", ack, 1);
    read_byte(1'b0, shadow[0], "R3 current address read byte 0");
    bus_stop();
    chk(mem_addr == 8'h01, "R3 counter advanced", mem_addr, 1);

    // R4 sequential read
    bus_start(); send_byte(DR, ack);
    read_byte(1'b1, shadow[1], "R4 sequential byte 1");
    read_byte(1'b1, shadow[2], "R4 sequential byte 2");
    read_byte(1'b0, shadow[3], "R4 sequential byte 3");
    chk(sda_pull == 1'b0, "R4 line released after no-ack", sda_pull, 0);
    bus_stop();
    chk(mem_addr == 8'h04, "R4 counter after three bytes", mem_addr, 4);

    // R2 mismatches
    bus_start(); send_byte(8'hA6, ack);
    chk(!ack, "R2 wrong select bits not acked", ack, 0);
    clock_in8(b);
    chk(b == 8'hFF, "R2 silent after mismatch", b, 8'hFF);
    bus_stop();
    bus_start(); send_byte(8'hB3, ack);
    chk(!ack, "R2 wrong code not acked", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hAB, ack);
    chk(!ack, "R2 bit3 set not acked", ack, 0);
    bus_stop();
    chk(mem_addr == 8'h04, "R2 counter untouched by mismatch", mem_addr, 4);

    // R5 address-only write, R7 wrap
    bus_start(); send_byte(DW, ack);
    chk(ack, "R2 matching write device byte acked", ack, 1);
    send_byte(8'hFE, ack);
    chk(ack, "R5 word address acked", ack, 1);
    bus_stop();
    tick(4);
    chk(mem_addr == 8'hFE, "R5 address-only write sets counter", mem_addr, 8'hFE);
    chk(we_cnt == 0, "R5 address-only write commits nothing", we_cnt, 0);
    bus_start(); send_byte(DR, ack);
    read_byte(1'b1, shadow[8'hFE], "R7 read at FE");
    read_byte(1'b1, shadow[8'hFF], "R7 read at FF");
    read_byte(1'b0, shadow[8'h00], "R7 wrapped read at 00");
    bus_stop();
    chk(mem_addr == 8'h01, "R7 counter wrapped", mem_addr, 1);

    // R5 byte write, R6 busy polling
    bus_start(); send_byte(DW, ack); send_byte(8'h40, ack);
    send_byte(8'h5C, ack);
    chk(ack, "R5 data byte acked", ack, 1);
    bus_stop();
    shadow[8'h40] = 8'h5C;
    tick(4);
    chk(we_cnt == 1, "R5 one write strobe", we_cnt, 1);
    chk(last_wa == 8'h40 && last_wd == 8'h5C, "R5 write address and data", {last_wa, last_wd}, 16'h405C);
    chk(mem_addr == 8'h41, "R5 counter after write", mem_addr, 8'h41);
    bus_start(); send_byte(DR, ack);
    chk(!ack, "R6 read poll refused while busy", ack, 0);
    bus_stop();
    bus_start(); send_byte(DW, ack);
    chk(!ack, "R6 write poll refused while busy", ack, 0);
    bus_stop();
    tick(WRC + 50);
    bus_start(); send_byte(DR, ack);
    chk(ack, "R6 acked after write cycle", ack, 1);
    read_byte(1'b0, shadow[8'h41], "R6 read after busy");
    bus_stop();

    // R8 random read via restart confirms stored byte
    bus_start(); send_byte(DW, ack); send_byte(8'h40, ack);
    bus_start(); send_byte(DR, ack);
    read_byte(1'b0, shadow[8'h40], "R8 random read of written byte");
    bus_stop();

    // R9 extra data byte refused
    bus_start(); send_byte(DW, ack); send_byte(8'h10, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    chk(!ack, "R9 second data byte not acked", ack, 0);
    bus_stop();
    shadow[8'h10] = 8'h11;
    tick(WRC + 50);
    chk(we_cnt == 2 && last_wd == 8'h11, "R9 only first byte committed", last_wd, 8'h11);

    // R8 restart discards held write
    bus_start(); send_byte(DW, ack); send_byte(8'h20, ack);
    send_byte(8'h99, ack);
    bus_start(); send_byte(DR, ack);
    chk(ack, "R8 restart reaches device byte", ack, 1);
    read_byte(1'b0, shadow[8'h20], "R8 held write discarded");
    bus_stop();
    tick(4);
    chk(we_cnt == 2, "R8 no write after restart", we_cnt, 2);
    chk(mem_addr == 8'h21, "R8 counter kept", mem_addr, 8'h21);

    // R11 stop inside ninth clock
    bus_start(); send_byte(DR, ack);
    exp_q.push_back(shadow[8'h21]); tag_q.push_back("R11 byte before stop");
    clock_in8(b); got_q.push_back(b);
    tick(H/2); m_sda = 1'b0; tick(H/2);
    scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
    chk(sda_pull == 1'b0, "R11 released after stop in ninth clock", sda_pull, 0);
    chk(mem_addr == 8'h22, "R11 counter after stopped read", mem_addr, 8'h22);
    bus_start(); send_byte(DR, ack);
    read_byte(1'b0, shadow[8'h22], "R11 next read continues");
    bus_stop();

    tick(20);
    chk(bad_edges == 0, "R10 data line changed only with clock low", bad_edges, 0);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule